// File: doc/BRIEF.md
# Inverter Dead-Time Compensator

Switch dead-times in an inverter leg shift the average output voltage away from the value the modulator was asked for. The error follows the sign of the load current. This block sits in front of the PWM modulator and corrects the duty set-point, one clock cycle at a time. It has two modes, chosen by a mode pin.

In open-loop mode the block adds a programmable correction magnitude to the requested duty. The sign of that correction is taken from the current reference, not from the measured current, so switching ripple cannot make it flip. A zero reference gives no correction, which leaves a dead zone at the current zero crossing.

In closed-loop mode the block times the real inverter output. Between two period strobes it counts the clock cycles in which the output is high and the cycles in which it is low. From those counts it computes the effective duty. It takes the difference between the set-point it issued for that period and the measured duty, and adds that difference to the requested duty for the following period. In both modes the result is clamped to the modulator's code range before it is registered.

Top module: `dtc_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sp_out` becomes 0 at that edge.
- R2: In open-loop mode (`mode` = 0), with `i_ref` greater than zero (two's complement), `sp_out` equals `sp_in + comp_mag`, clamped per R5, one clock after the inputs are applied.
- R3: In open-loop mode, with `i_ref` below zero, `sp_out` equals `sp_in - comp_mag`, clamped per R5, one clock later.
- R4: In open-loop mode, with `i_ref` equal to zero, `sp_out` equals `sp_in` one clock later, for any `comp_mag`.
- R5: Duty codes are unsigned, with 0 meaning 0 % and DMAX = 2^DUTY_W-1 meaning 100 %. A corrected value below 0 is output as 0, and one above DMAX is output as DMAX.
- R6: In closed-loop mode (`mode` = 1), consider a period that runs from one `period_start` cycle up to the cycle before the next one, with the strobe cycle included. In that period the high cycles H and low cycles L of `out_level` are counted, and I is the value `sp_out` held at the clock edge that opened the period. Within DUTY_W+4 clocks after the closing strobe, `sp_out` becomes the clamp of `sp_in + I - floor(H*DMAX/(H+L))`.
- R7: In closed-loop mode the correction term stays constant between two measurement results, so `sp_out` stays steady while `sp_in` is steady.
- R8: In closed-loop mode, `i_ref` and `comp_mag` have no effect on `sp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | 0 = open-loop correction, 1 = closed-loop correction |
| period_start | input | 1 | One-cycle strobe at the start of each modulation period |
| sp_in | input | DUTY_W | Requested duty set-point |
| i_ref | input | IREF_W | Current reference, signed |
| comp_mag | input | DUTY_W | Open-loop correction magnitude |
| out_level | input | 1 | Sensed inverter output level, synchronous, 1 = high |
| sp_out | output | DUTY_W | Corrected duty set-point for the modulator |

## Verification
The open-loop sweep covers every current-sign case against a range of set-points and magnitudes, with extra cases at both ends of the code range. A sign taken the wrong way round would move the duty the wrong way. A missing dead zone would push a zero-current leg off its set-point. A missing clamp would wrap a near-full duty to near zero.

The closed-loop run drives pulse trains with zero, full and intermediate high times, and checks the output in the middle of each period and again at its end. Four design errors would each show up here:
- pairing the measurement with the wrong issued value would give the correction from an adjacent period;
- dropping the strobe cycle from the count would bias the measured duty;
- letting the correction drift would change the output inside a period;
- an open-loop path leaking into closed-loop mode would show as the reference sign toggling the output.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
    // Correction mode selected by the mode pin
    typedef enum logic {
        MODE_OPEN   = 1'b0,
        MODE_CLOSED = 1'b1
    } dtc_mode_e;
endpackage

// File: rtl/dtc_pulse_timer.sv
// Counts high and low clock cycles of the inverter output within each
// modulation period. Assumes out_level is already synchronous to clk.
// The strobe cycle belongs to the new period; counts saturate at their maximum.
module dtc_pulse_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_start,
    input  logic             out_level,
    output logic [CNT_W-1:0] hi_cap,
    output logic [CNT_W-1:0] lo_cap,
    output logic             cap_valid
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;

    // Count the output level and capture the totals on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            hi_cap    <= '0;
            lo_cap    <= '0;
            cap_valid <= 1'b0;
        end else if (period_start) begin
            hi_cap    <= hi_cnt;
            lo_cap    <= lo_cnt;
            cap_valid <= 1'b1;
            hi_cnt    <= {{(CNT_W-1){1'b0}}, out_level};
            lo_cnt    <= {{(CNT_W-1){1'b0}}, ~out_level};
        end else begin
            cap_valid <= 1'b0;
            if (out_level && hi_cnt != CMAX)
                hi_cnt <= hi_cnt + 1'b1;
            if (!out_level && lo_cnt != CMAX)
                lo_cnt <= lo_cnt + 1'b1;
        end
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> (({1'b0, hi_cnt} + {1'b0, lo_cnt}) == (CNT_W+1)'(1))); // R6
endmodule

// File: rtl/dtc_duty_div.sv
// Sequential restoring divider that gives floor(hi*DMAX/(hi+lo)).
// Produces one quotient bit per clock, MSB first, so it finishes DUTY_W
// clocks after start. Assumes start does not come again while it is busy.
module dtc_duty_div #(
    parameter int CNT_W  = 10,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  hi,
    input  logic [CNT_W-1:0]  lo,
    output logic [DUTY_W-1:0] duty,
    output logic              done,
    output logic              zero_den
);
    localparam int NUM_W  = CNT_W + DUTY_W;
    localparam int DEN_W  = CNT_W + 1;
    localparam int SH_W   = DEN_W + DUTY_W;
    localparam int STEP_W = $clog2(DUTY_W + 1);
    localparam logic [NUM_W-1:0] DMAX_N = NUM_W'((1 << DUTY_W) - 1);

    logic [NUM_W-1:0]  rem;
    logic [SH_W-1:0]   dsh;
    logic [STEP_W-1:0] step;
    logic              busy;
    logic [NUM_W-1:0]  num_r;
    logic [DEN_W-1:0]  den_r;
    logic [DEN_W-1:0]  den_in;

    // Period length used as the divisor
    always_comb den_in = {1'b0, hi} + {1'b0, lo};

    // Load the operands, then produce one quotient bit per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            dsh      <= '0;
            step     <= '0;
            busy     <= 1'b0;
            duty     <= '0;
            done     <= 1'b0;
            zero_den <= 1'b0;
            num_r    <= '0;
            den_r    <= '0;
        end else if (start) begin
            rem      <= NUM_W'(hi) * DMAX_N;
            num_r    <= NUM_W'(hi) * DMAX_N;
            den_r    <= den_in;
            dsh      <= SH_W'(den_in) << (DUTY_W - 1);
            step     <= STEP_W'(DUTY_W);
            busy     <= 1'b1;
            duty     <= '0;
            done     <= 1'b0;
            zero_den <= (den_in == '0);
        end else if (busy) begin
            if (SH_W'(rem) >= dsh) begin
                rem  <= rem - NUM_W'(dsh);
                duty <= {duty[DUTY_W-2:0], 1'b1};
            end else begin
                duty <= {duty[DUTY_W-2:0], 1'b0};
            end
            dsh  <= dsh >> 1;
            step <= step - 1'b1;
            if (step == STEP_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !zero_den) |->
            (((SH_W+1)'(duty) * (SH_W+1)'(den_r) <= (SH_W+1)'(num_r)) &&
             ((SH_W+1)'(num_r) < ((SH_W+1)'(duty) + 1'b1) * (SH_W+1)'(den_r)))); // R6
endmodule

// File: rtl/dtc_corr_unit.sv
// Keeps the set-point issued for the current and the previous period. When a
// measurement completes, it forms the closed-loop correction
// issued - measured. Assumes the measurement finishes before the next strobe.
module dtc_corr_unit #(
    parameter int DUTY_W = 8,
    localparam int CW    = DUTY_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 period_start,
    input  logic [DUTY_W-1:0]    sp_now,
    input  logic                 meas_done,
    input  logic                 meas_zero,
    input  logic [DUTY_W-1:0]    meas_duty,
    output logic signed [CW-1:0] corr
);
    logic [DUTY_W-1:0] issued_live;
    logic [DUTY_W-1:0] issued_cap;

    // Record the issued set-point at each strobe and pair it with the next result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued_live <= '0;
            issued_cap  <= '0;
        end else if (period_start) begin
            issued_cap  <= issued_live;
            issued_live <= sp_now;
        end
    end

    // Update the correction only when a measurement completes
    always_ff @(posedge clk) begin
        if (!rst_n)
            corr <= '0;
        else if (meas_done)
            corr <= meas_zero ? '0
                  : ($signed({2'b00, issued_cap}) - $signed({2'b00, meas_duty}));
    end

    AST_CORR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_done |=> $stable(corr)); // R7
endmodule

// File: rtl/dtc_top.sv
// Dead-time compensator top. Chooses the open-loop correction (its sign from
// the current reference) or the closed-loop correction (from measured output
// pulses), adds it to the requested duty, clamps the sum and registers it.
// Assumes each period lasts longer than DUTY_W+4 clocks.
module dtc_top #(
    parameter int DUTY_W = 8,
    parameter int CNT_W  = 10,
    parameter int IREF_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode,
    input  logic                     period_start,
    input  logic [DUTY_W-1:0]        sp_in,
    input  logic signed [IREF_W-1:0] i_ref,
    input  logic [DUTY_W-1:0]        comp_mag,
    input  logic                     out_level,
    output logic [DUTY_W-1:0]        sp_out
);
    import dtc_pkg::*;

    localparam int CW = DUTY_W + 2;
    localparam logic signed [CW-1:0] DMAX_S = CW'((1 << DUTY_W) - 1);

    dtc_mode_e             mode_e;
    logic [CNT_W-1:0]      hi_cap;
    logic [CNT_W-1:0]      lo_cap;
    logic                  cap_valid;
    logic [DUTY_W-1:0]     meas_duty;
    logic                  meas_done;
    logic                  meas_zero;
    logic signed [CW-1:0]  cl_corr;
    logic signed [CW-1:0]  ol_corr;
    logic signed [CW-1:0]  corr_sel;
    logic signed [CW-1:0]  sum;
    logic [DUTY_W-1:0]     sat_val;

    assign mode_e = dtc_mode_e'(mode);

    dtc_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .out_level    (out_level),
        .hi_cap       (hi_cap),
        .lo_cap       (lo_cap),
        .cap_valid    (cap_valid)
    );

    dtc_duty_div #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cap_valid),
        .hi       (hi_cap),
        .lo       (lo_cap),
        .duty     (meas_duty),
        .done     (meas_done),
        .zero_den (meas_zero)
    );

    dtc_corr_unit #(.DUTY_W(DUTY_W)) u_corr (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .sp_now       (sp_out),
        .meas_done    (meas_done),
        .meas_zero    (meas_zero),
        .meas_duty    (meas_duty),
        .corr         (cl_corr)
    );

    // Open-loop correction, signed by the current reference, zero at zero current
    always_comb begin
        if (i_ref > 0)
            ol_corr = $signed({2'b00, comp_mag});
        else if (i_ref < 0)
            ol_corr = -$signed({2'b00, comp_mag});
        else
            ol_corr = '0;
    end

    // Pick the correction for the mode, add it to the request and clamp
    always_comb begin
        corr_sel = (mode_e == MODE_CLOSED) ? cl_corr : ol_corr;
        sum      = $signed({2'b00, sp_in}) + corr_sel;
        if (sum < 0)
            sat_val = '0;
        else if (sum > DMAX_S)
            sat_val = DMAX_S[DUTY_W-1:0];
        else
            sat_val = sum[DUTY_W-1:0];
    end

    // Register the corrected set-point for the modulator
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_out <= '0;
        else
            sp_out <= sat_val;
    end

    AST_DEAD_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_OPEN && i_ref == 0) |=> (sp_out == $past(sp_in))); // R4
    AST_OPEN_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_OPEN && i_ref > 0) |=> (sp_out >= $past(sp_in))); // R2
    AST_OPEN_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_OPEN && i_ref < 0) |=> (sp_out <= $past(sp_in))); // R3
endmodule

// File: tb/sim_dtc_top.sv
module sim_dtc_top;
    localparam int DUTY_W = 8;
    localparam int CNT_W  = 10;
    localparam int IREF_W = 12;
    localparam int DMAX   = (1 << DUTY_W) - 1;
    localparam int P      = 64;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     mode = 1'b0;
    logic                     period_start = 1'b0;
    logic [DUTY_W-1:0]        sp_in = '0;
    logic signed [IREF_W-1:0] i_ref = '0;
    logic [DUTY_W-1:0]        comp_mag = '0;
    logic                     out_level = 1'b0;
    logic [DUTY_W-1:0]        sp_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dtc_top #(.DUTY_W(DUTY_W), .CNT_W(CNT_W), .IREF_W(IREF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .period_start(period_start),
        .sp_in(sp_in), .i_ref(i_ref), .comp_mag(comp_mag),
        .out_level(out_level), .sp_out(sp_out)
    );

    function automatic int clampv(input int v);
        if (v < 0) return 0;
        if (v > DMAX) return DMAX;
        return v;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One modulation period: strobe, H high cycles, then low cycles
    int  prev_i, prev_h, cl_sp;
    bit  have_prev;
    bit  iref_flip;
    task automatic run_period(input int h);
        int cur_i, exp_v;
        cur_i = 0;
        exp_v = have_prev ? clampv(cl_sp + prev_i - (prev_h * DMAX) / P) : 0;
        for (int j = 0; j < P; j++) begin
            period_start = (j == 0);
            out_level    = (j < h);
            if (j == 0) cur_i = int'(sp_out);
            if (j == 20 && have_prev) check(int'(sp_out), exp_v, "R6 closed-loop correction");
            if (j == 30) begin
                iref_flip = ~iref_flip;
                i_ref     = iref_flip ? -12'sd700 : 12'sd700;
                comp_mag  = iref_flip ? 8'd0 : 8'd90;
            end
            if (j == P-1 && have_prev) check(int'(sp_out), exp_v, "R7/R8 hold, ignore i_ref");
            @(negedge clk);
        end
        prev_i = cur_i;
        prev_h = h;
        have_prev = 1'b1;
    endtask

    initial begin
        int mags[3];
        int irefs[5];
        int s;
        mags  = '{0, 5, 40};
        irefs = '{-300, 0, 1, -1, 2047};
        sp_in = 8'd50; i_ref = 12'sd100; comp_mag = 8'd9;
        repeat (3) @(negedge clk);
        check(int'(sp_out), 0, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // Open-loop sweep over set-point, magnitude and reference sign
        for (int sp = 0; sp <= DMAX; sp += 17) begin
            for (int m = 0; m < 3; m++) begin
                for (int r = 0; r < 5; r++) begin
                    sp_in = sp[DUTY_W-1:0]; comp_mag = mags[m][DUTY_W-1:0];
                    i_ref = irefs[r][IREF_W-1:0];
                    @(negedge clk);
                    s = (irefs[r] > 0) ? 1 : (irefs[r] < 0) ? -1 : 0;
                    if (sp + s*mags[m] < 0 || sp + s*mags[m] > DMAX)
                        check(int'(sp_out), clampv(sp + s*mags[m]), "R5 clamp");
                    else if (s > 0)
                        check(int'(sp_out), sp + mags[m], "R2 positive ref");
                    else if (s < 0)
                        check(int'(sp_out), sp - mags[m], "R3 negative ref");
                    else
                        check(int'(sp_out), sp, "R4 dead zone");
                end
            end
        end
        // Clamp edges
        sp_in = 8'd250; comp_mag = 8'd10; i_ref = 12'sd3; @(negedge clk);
        check(int'(sp_out), DMAX, "R5 clamp high");
        sp_in = 8'd4; comp_mag = 8'd10; i_ref = -12'sd3; @(negedge clk);
        check(int'(sp_out), 0, "R5 clamp low");
        sp_in = 8'd255; comp_mag = 8'd255; i_ref = 12'sd0; @(negedge clk);
        check(int'(sp_out), 255, "R4 dead zone at full scale");

        // Closed-loop periods with varied high times
        mode = 1'b1; cl_sp = 100; sp_in = 8'd100; have_prev = 1'b0; iref_flip = 1'b0;
        @(negedge clk);
        run_period(20);
        run_period(30);
        run_period(0);
        run_period(64);
        run_period(50);
        run_period(10);
        run_period(40);
        run_period(63);
        run_period(1);
        run_period(32);
        period_start = 1'b0;

        // Back to open loop
        mode = 1'b0; sp_in = 8'd120; comp_mag = 8'd7; i_ref = -12'sd5;
        @(negedge clk);
        check(int'(sp_out), 113, "R3 after mode return");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule